// File: doc/BRIEF.md
# Dual-Read Single-Write Register File

This block holds the integer registers of a small processor core: thirty-two entries of thirty-two bits by default. Two read ports each take a register index and return that entry's contents combinationally, in the same cycle. One write port stores a value on the rising clock edge when its enable is high. Entry zero is fixed at zero. Writes to it are dropped.

A build-time mode parameter decides what a read port returns when it addresses the register being written in the same cycle. The read-old mode returns the contents held before the edge, which suits a core that finishes one instruction per cycle. The write-first mode bypasses the incoming write data to the read port, which suits a pipeline whose writeback and decode stages share a cycle. A synchronous active-high clear sets every entry to zero.

Top module: `regfile_2r1w`

## Requirements
- R1: In one cycle, both read ports and the write port can operate on three different registers. Each read port returns the stored value of its own register.
- R2: Read data is combinational. It follows a change of read address within the same cycle, with no clock edge in between.
- R3: An entry is updated only at a rising clock edge where `wr_en` is 1. While `wr_en` is 0, the contents stay unchanged.
- R4: With `MODE = RF_READ_OLD`, a read of the register being written in the same cycle returns the value held before that write.
- R5: With `MODE = RF_WRITE_FIRST`, a read of a non-zero register being written in the same cycle returns `wr_data`. This happens only when `wr_en` is 1 and `rst` is 0.
- R6: When `rst` is 1 at a rising edge, every entry becomes zero. A write in the same cycle is discarded. No write data is bypassed while `rst` is 1.
- R7: Register index 0 always reads as zero in both modes. A write to it is ignored and is never bypassed.
- R8: When both read ports address the same register, they return identical data.
- R9: An entry keeps its value until it is written again or cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear of all entries |
| rd_addr_a | input | ADDR_W | Read port A register index |
| rd_data_a | output | DATA_W | Read port A data |
| rd_addr_b | input | ADDR_W | Read port B register index |
| rd_data_b | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Write register index |
| wr_data | input | DATA_W | Write data |

## Verification
Several properties are checked on every cycle:
- the zero register always reads as zero;
- the two ports agree when they share an address;
- a completed write is visible at the next edge;
- a clear is visible at the next edge;
- data held at a stable address stays unchanged when that address is not written;
- in write-first mode, a collision returns the write data.

Read-old collision behaviour needs the bench. So do clear-over-write priority and the combinational response to an address change within a cycle. The bench covers these by comparing both mode variants against a behavioural model on every cycle, through directed collisions and a long random run.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic {RF_READ_OLD = 1'b0, RF_WRITE_FIRST = 1'b1} rf_mode_e;
  localparam int unsigned RF_DEF_REGS = 32;
  localparam int unsigned RF_DEF_WIDTH = 32;
endpackage

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  entries
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (wr_en && (wr_addr != '0)) begin
      mem[wr_addr] <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    if (g == 0) begin : g_zero
      assign entries[g] = '0;
    end else begin : g_live
      assign entries[g] = mem[g];
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter rf_mode_e    MODE     = RF_READ_OLD,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] entries,
  input  logic [ADDR_W-1:0]               rd_addr,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [DATA_W-1:0]               rd_data
);
  logic [DATA_W-1:0] stored;
  assign stored = entries[rd_addr];

  if (MODE == RF_WRITE_FIRST) begin : g_bypass
    logic hit;
    assign hit = wr_en && !rst && (wr_addr != '0) && (wr_addr == rd_addr);
    assign rd_data = hit ? wr_data : stored;
  end else begin : g_plain
    logic unused_ok;
    assign unused_ok = ^{rst, wr_en, wr_addr, wr_data};
    assign rd_data = stored;
  end
endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w
  import rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = RF_DEF_REGS,
  parameter int unsigned DATA_W   = RF_DEF_WIDTH,
  parameter rf_mode_e    MODE     = RF_READ_OLD,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int unsigned NUM_RD = 2;

  logic [NUM_REGS-1:0][DATA_W-1:0] entries;
  logic [NUM_RD-1:0][ADDR_W-1:0]   raddr;
  logic [NUM_RD-1:0][DATA_W-1:0]   rdata;

  assign raddr[0]  = rd_addr_a;
  assign raddr[1]  = rd_addr_b;
  assign rd_data_a = rdata[0];
  assign rd_data_b = rdata[1];

  rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .entries(entries)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .MODE(MODE)) u_port (
      .entries(entries), .rd_addr(raddr[p]), .rst(rst), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rdata[p])
    );
  end
endmodule

// File: rtl/rf_checker.sv
module rf_checker
  import rf_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter rf_mode_e    MODE   = RF_READ_OLD
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rd_addr_a,
  input logic [DATA_W-1:0] rd_data_a,
  input logic [ADDR_W-1:0] rd_addr_b,
  input logic [DATA_W-1:0] rd_data_b,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  logic coll_a;
  assign coll_a = wr_en && (wr_addr == rd_addr_a);

  AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == '0) |-> (rd_data_a == '0)); // R7
  AST_ZERO_REG_B: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_b == '0) |-> (rd_data_b == '0)); // R7
  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b)); // R8
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr != '0)) |=>
      ((rd_addr_a != $past(wr_addr)) || coll_a || (rd_data_a == $past(wr_data)))); // R3
  AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (rst)
    ($stable(rd_addr_a) && !$past(rst) && !$past(coll_a) && !coll_a) |-> $stable(rd_data_a)); // R9
  AST_CLEARED: assert property (@(posedge clk)
    ($past(rst) && !rst && !(MODE == RF_WRITE_FIRST && coll_a)) |-> (rd_data_a == '0)); // R6

  if (MODE == RF_WRITE_FIRST) begin : g_wf
    AST_BYPASS: assert property (@(posedge clk) disable iff (rst)
      (coll_a && (wr_addr != '0)) |-> (rd_data_a == wr_data)); // R5
  end
endmodule

bind regfile_2r1w rf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE(MODE)) u_rf_chk (
  .clk(clk), .rst(rst), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
  .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/test_regfile_2r1w.sv
`timescale 1ns/1ps
module test_regfile_2r1w;
  import rf_pkg::*;
  localparam int N = 32;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 0;
  logic rst = 1;
  logic [AW-1:0] ra = '0, rb = '0, wa = '0;
  logic [DW-1:0] wd = '0;
  logic we = 0;
  logic [DW-1:0] da_ro, db_ro, da_wf, db_wf;

  int compared = 0, mismatched = 0;
  logic [DW-1:0] model [N];

  always #2.5 clk = ~clk;

  regfile_2r1w #(.MODE(RF_READ_OLD)) i_regfile_2r1w (
    .clk(clk), .rst(rst), .rd_addr_a(ra), .rd_data_a(da_ro), .rd_addr_b(rb),
    .rd_data_b(db_ro), .wr_en(we), .wr_addr(wa), .wr_data(wd));
  regfile_2r1w #(.MODE(RF_WRITE_FIRST)) i_regfile_2r1w_wf (
    .clk(clk), .rst(rst), .rd_addr_a(ra), .rd_data_a(da_wf), .rd_addr_b(rb),
    .rd_data_b(db_wf), .wr_en(we), .wr_addr(wa), .wr_data(wd));

  function automatic logic [DW-1:0] expect_rd(logic [AW-1:0] a, bit wf);
    if (a == 0) return '0;
    if (wf && we && !rst && wa == a) return wd;
    return model[a];
  endfunction

  function automatic string tag_of(logic [AW-1:0] a, bit wf, string dflt);
    if (a == 0) return "R7";
    if (we && !rst && wa == a) return wf ? "R5" : "R4";
    return dflt;
  endfunction

  task automatic chk1(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(string dflt);
    chk1(tag_of(ra, 0, dflt), "ro port A", da_ro, expect_rd(ra, 0));
    chk1(tag_of(rb, 0, dflt), "ro port B", db_ro, expect_rd(rb, 0));
    chk1(tag_of(ra, 1, dflt), "wf port A", da_wf, expect_rd(ra, 1));
    chk1(tag_of(rb, 1, dflt), "wf port B", db_wf, expect_rd(rb, 1));
    if (ra == rb) begin
      chk1("R8", "ro ports agree", da_ro, db_ro);
      chk1("R8", "wf ports agree", da_wf, db_wf);
    end
  endtask

  // One cycle: drive after the falling edge, compare, then commit the model at the rising edge.
  task automatic cyc(bit r, bit e, logic [AW-1:0] w, logic [DW-1:0] d,
                     logic [AW-1:0] a, logic [AW-1:0] b, string dflt);
    @(negedge clk);
    rst = r; we = e; wa = w; wd = d; ra = a; rb = b;
    #1 compare_all(dflt);
    @(posedge clk);
    if (r) for (int i = 0; i < N; i++) model[i] = '0;
    else if (e && w != 0) model[w] = d;
  endtask

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    cyc(1, 0, 0, 0, 0, 0, "R6");
    cyc(1, 0, 0, 0, 0, 0, "R6");
    // reset state: every entry zero (R6)
    for (int i = 0; i < N; i++) cyc(0, 0, 0, 0, AW'(i), AW'(N-1-i), "R6");
    // fill all entries; reads lag one behind (R1, R3)
    for (int i = 1; i < N; i++)
      cyc(0, 1, AW'(i), 32'hA500_0000 + i, AW'(i-1), AW'((i+7)%N), "R1");
    // combinational read: address change between edges (R2)
    @(negedge clk); we = 0; ra = 5; rb = 9;
    #0.5 chk1("R2", "ro A addr5", da_ro, model[5]);
    ra = 12; rb = 3;
    #0.5 chk1("R2", "ro A addr12", da_ro, model[12]);
    chk1("R2", "wf B addr3", db_wf, model[3]);
    // enable low: write ignored, value persists (R3, R9)
    cyc(0, 0, 7, 32'hDEAD_BEEF, 1, 2, "R3");
    cyc(0, 0, 0, 0, 7, 7, "R3");
    // same-cycle collision, both ports on written reg (R4, R5, R8)
    cyc(0, 1, 10, 32'h1234_5678, 10, 10, "R4");
    cyc(0, 0, 0, 0, 10, 11, "R9");
    // x0 write ignored and not bypassed (R7)
    cyc(0, 1, 0, 32'hFFFF_FFFF, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, 1, "R7");
    // clear with a simultaneous write: clear wins, no bypass (R6)
    cyc(1, 1, 4, 32'hCAFE_F00D, 4, 5, "R6");
    cyc(0, 0, 0, 0, 4, 5, "R6");
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      automatic logic [AW-1:0] w = AW'($urandom_range(0, N-1));
      automatic logic [AW-1:0] a = ($urandom_range(0, 3) == 0) ? w : AW'($urandom_range(0, N-1));
      automatic logic [AW-1:0] b = ($urandom_range(0, 3) == 0) ? a : AW'($urandom_range(0, N-1));
      cyc(($urandom_range(0, 199) == 0), $urandom_range(0, 1), w, $urandom, a, b, "R9");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule